// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked user port and an external asynchronous static RAM that holds 524,288 words of 16 bits. A single request with a write flag, a word address, write data and two byte enables is turned into a complete memory access. The access has registered, glitch-free active-low strobes for chip select, write, output enable and the two byte lanes, and it controls the direction of the shared data bus. Every access minimum is given in nanoseconds. It is converted to whole clock cycles by rounding up against the clock period, so the same block runs at other clock rates by changing parameters only.

The controller is a five-state machine. `ST_IDLE` keeps the chip deselected so that the memory stays in low-power standby, and it is the only state in which `req_ready` is high. *Accept-read* moves `ST_IDLE` to `ST_READ`. *Accept-write* moves `ST_IDLE` to `ST_WRITE`, or to `ST_TURN` when the previous transfer was a read. *Read-done* moves `ST_READ` back to `ST_IDLE` and captures the data. *Turn-done* moves `ST_TURN` to `ST_WRITE`. *Pulse-done* moves `ST_WRITE` to `ST_WTAIL`. *Tail-done* moves `ST_WTAIL` to `ST_IDLE`.

With the default 5 ns clock the counts are as follows. A read holds the memory selected for 11 cycles. A write-enable pulse lasts 9 cycles and is followed by 2 cycles of recovery, so the chip is selected for 11 cycles. A write that follows a read is delayed by a 4-cycle bus-release gap.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all high, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the access has finished, and a request presented while `req_ready` is low has no effect.
- R3: A read keeps `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for exactly ceil(max(read cycle, address access)/period) cycles, which is 11 by default, and `mem_addr` holds the request address throughout.
- R4: The read word is captured on the edge that ends the read interval. `rsp_valid` is high for exactly one cycle, and `req_ready` rises in that same cycle.
- R5: A write drives `mem_we_n` low for ceil(max(write pulse, data setup)/period) cycles, 9 by default. `mem_ce_n` stays low for ceil(write cycle/period) cycles, 11 by default. `mem_oe_n` stays high for the whole write.
- R6: `mem_dq_oe` is high exactly while `mem_we_n` is low, and during that time `mem_dq_o` carries the request's write data.
- R7: `req_be[0]` controls the lower lane (data bits 7:0, strobe `mem_lb_n`) and `req_be[1]` controls the upper lane (bits 15:8, strobe `mem_ub_n`). A lane's strobe is low during the access only when its enable is 1. A write changes only the enabled lanes, and a read returns zero in the bits of disabled lanes.
- R8: A write accepted right after a read spends ceil(bus release/period) cycles, 4 by default, with all strobes high and the driver off before `mem_we_n` falls. A write accepted after a write starts its pulse on the acceptance edge.
- R9: Whenever the controller is idle (`req_ready` high), `mem_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 for the lower lane |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data driven towards the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
Every strobe changes one cycle after the state decision that causes it, because the strobes are registered from the next state. The bench therefore samples on falling edges, starting with the first falling edge after the accepting rising edge, and counts the samples in which each strobe is low. A read must show 11 samples with select and output enable low, followed by a sample in which `rsp_valid` and `req_ready` are high together and the data can be compared. A write must show a 9-sample write pulse inside an 11-sample select window. A write after a read must show 4 leading samples with the write pulse not yet started, and a write after a write must show none.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_WTAIL
    } ctl_state_t;

    // Whole clock cycles covering a nanosecond minimum, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3, R5: an expired interval stays expired until reloaded.
    p_timer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sram_lane_select.sv
`timescale 1ns/1ps
module sram_lane_select #(
    parameter int LANES  = 2,
    parameter int DATA_W = 16
) (
    input  logic [LANES-1:0]  be,
    input  logic              active,
    input  logic [DATA_W-1:0] bus_in,
    output logic [LANES-1:0]  lane_on,
    output logic [DATA_W-1:0] bus_masked
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_on[g] = active & be[g];
        assign bus_masked[g*LANE_W +: LANE_W] = be[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 16,
    parameter int CLK_NS  = 5,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_WC_NS = 55,
    parameter int T_WP_NS = 45,
    parameter int T_DW_NS = 30,
    parameter int T_HZ_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int LANES   = 2;
    localparam int RD_CYC  = ns_to_cyc(max2(T_RC_NS, T_AA_NS), CLK_NS);
    localparam int WP_CYC  = ns_to_cyc(max2(T_WP_NS, T_DW_NS), CLK_NS);
    localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int TL_CYC  = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int TN_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(TL_CYC, TN_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_t        state_q, state_d;
    logic              after_read_q, after_read_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] wdata_q, wdata_d;
    logic [LANES-1:0]  be_q, be_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              lane_active;
    logic [LANES-1:0]  lane_on;
    logic [DATA_W-1:0] rd_masked;
    logic              accept;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // The byte strobes follow the next state, so they line up with the select.
    assign lane_active = (state_d == ST_READ) || (state_d == ST_WRITE) || (state_d == ST_WTAIL);

    sram_lane_select #(.LANES(LANES), .DATA_W(DATA_W)) u_lanes (
        .be         (be_d),
        .active     (lane_active),
        .bus_in     (mem_dq_i),
        .lane_on    (lane_on),
        .bus_masked (rd_masked)
    );

    assign accept = req_valid && req_ready;

    // Next-state and timer control.
    always_comb begin
        state_d      = state_q;
        after_read_d = after_read_q;
        addr_d       = addr_q;
        wdata_d      = wdata_q;
        be_d         = be_q;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    addr_d   = req_addr;
                    wdata_d  = req_wdata;
                    be_d     = req_be;
                    tmr_load = 1'b1;
                    if (!req_write) begin
                        state_d = ST_READ;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end else if (after_read_q) begin
                        state_d = ST_TURN;
                        tmr_val = CNT_W'(TN_CYC - 1);
                    end else begin
                        state_d = ST_WRITE;
                        tmr_val = CNT_W'(WP_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    state_d      = ST_IDLE;
                    after_read_d = 1'b1;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    state_d  = ST_WRITE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WRITE: begin
                after_read_d = 1'b0;
                if (tmr_done) begin
                    state_d  = ST_WTAIL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TL_CYC - 1);
                end
            end
            ST_WTAIL: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            after_read_q <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
            be_q         <= '0;
        end else begin
            state_q      <= state_d;
            after_read_q <= after_read_d;
            addr_q       <= addr_d;
            wdata_q      <= wdata_d;
            be_q         <= be_d;
        end
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_ready <= 1'b1;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            mem_addr  <= '0;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_o  <= '0;
            mem_dq_oe <= 1'b0;
        end else begin
            req_ready <= (state_d == ST_IDLE);
            rsp_valid <= (state_q == ST_READ) && tmr_done;
            if ((state_q == ST_READ) && tmr_done) rsp_rdata <= rd_masked;
            mem_addr  <= addr_d;
            mem_ce_n  <= !lane_active;
            mem_we_n  <= (state_d != ST_WRITE);
            mem_oe_n  <= (state_d != ST_READ);
            mem_lb_n  <= !lane_on[0];
            mem_ub_n  <= !lane_on[1];
            mem_dq_o  <= wdata_d;
            mem_dq_oe <= (state_d == ST_WRITE);
        end
    end

    p_drive_only_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);
    p_no_oe_during_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));
    p_idle_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    p_lane_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_lb_n || !mem_ub_n) |-> !mem_ce_n);
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_sram_strobe_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [0:255];

    always #2.5 clk = ~clk;

    sram_strobe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: enabled lanes return stored data, floating lanes read 8'hEE.
    always_comb begin
        mem_dq_i[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? model[mem_addr[7:0]][7:0]  : 8'hEE;
        mem_dq_i[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? model[mem_addr[7:0]][15:8] : 8'hEE;
    end

    always @(posedge clk) begin
        if (rst_n && !mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) model[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_ub_n) model[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n, "R1 strobes",
            {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1F);
        chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 ready/valid/oe",
            {29'd0, mem_dq_oe, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic t_read(input logic [18:0] a, input logic [1:0] be);
        logic [15:0] exp;
        int n_acc = 0, strobe_bad = 0, addr_bad = 0;
        exp = {be[1] ? model[a[7:0]][15:8] : 8'h00, be[0] ? model[a[7:0]][7:0] : 8'h00};
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after read accept", {31'd0, req_ready}, 32'd0);
        for (int g = 0; g < 100 && !req_ready; g++) begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n) n_acc++;
            if (mem_lb_n != !be[0] || mem_ub_n != !be[1]) strobe_bad++;
            if (mem_addr != a) addr_bad++;
            @(negedge clk);
        end
        chk(n_acc == 11, "R3 read window cycles", n_acc, 11);
        chk(addr_bad == 0, "R3 address held", addr_bad, 0);
        chk(strobe_bad == 0, "R7 read lane strobes", strobe_bad, 0);
        chk(rsp_valid, "R4 valid with ready", {31'd0, rsp_valid}, 1);
        chk(rsp_rdata == exp, "R4 R7 read data", {16'd0, rsp_rdata}, {16'd0, exp});
        chk(mem_ce_n, "R9 idle deselected", {31'd0, mem_ce_n}, 1);
        @(negedge clk);
        chk(!rsp_valid, "R4 valid one cycle", {31'd0, rsp_valid}, 0);
    endtask

    task automatic t_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be,
                           input int exp_lead, input bit poke);
        logic [15:0] exp, poke_old;
        int n_we = 0, n_ce = 0, lead = 0, dq_bad = 0, oe_bad = 0, strobe_bad = 0;
        exp = model[a[7:0]];
        if (be[0]) exp[7:0] = d[7:0];
        if (be[1]) exp[15:8] = d[15:8];
        poke_old = model[8'h33];
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after write accept", {31'd0, req_ready}, 0);
        if (poke) begin
            req_valid = 1'b1; req_addr = 19'h33; req_wdata = 16'hDEAD; req_be = 2'b11;
        end
        for (int g = 0; g < 100 && !req_ready; g++) begin
            if (!mem_ce_n) n_ce++;
            if (!mem_we_n) begin
                n_we++;
                if (!mem_dq_oe || mem_dq_o != d) dq_bad++;
                if (mem_lb_n != !be[0] || mem_ub_n != !be[1]) strobe_bad++;
            end else begin
                if (mem_dq_oe) dq_bad++;
                if (n_we == 0) lead++;
            end
            if (!mem_oe_n) oe_bad++;
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk(n_we == 9, "R5 write pulse cycles", n_we, 9);
        chk(n_ce == 11, "R5 select cycles in write", n_ce, 11);
        chk(oe_bad == 0, "R5 output enable high in write", oe_bad, 0);
        chk(dq_bad == 0, "R6 driver only during pulse", dq_bad, 0);
        chk(strobe_bad == 0, "R7 write lane strobes", strobe_bad, 0);
        chk(lead == exp_lead, "R8 lead before pulse", lead, exp_lead);
        chk(model[a[7:0]] == exp, "R7 stored lanes", {16'd0, model[a[7:0]]}, {16'd0, exp});
        if (poke) begin
            int sel = 0;
            for (int k = 0; k < 4; k++) begin
                if (!mem_ce_n) sel++;
                @(negedge clk);
            end
            chk(sel == 0, "R2 ignored request no access", sel, 0);
            chk(model[8'h33] == poke_old, "R2 ignored request no write",
                {16'd0, model[8'h33]}, {16'd0, poke_old});
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'h5A00 ^ (16'(i) * 16'h0103);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_read(19'h00010, 2'b11);
        t_write(19'h00020, 16'hA1B2, 2'b11, 4, 1'b0);
        t_write(19'h00021, 16'hC3D4, 2'b01, 0, 1'b0);
        t_write(19'h00022, 16'hE5F6, 2'b10, 0, 1'b1);
        t_read(19'h00021, 2'b11);
        t_read(19'h00020, 2'b01);
        t_read(19'h00022, 2'b10);
        t_write(19'h7FF40, 16'h1357, 2'b11, 4, 1'b0);
        t_read(19'h7FF40, 2'b11);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule